// File: doc/BRIEF.md
# Bit-Sliced Unsigned Dot-Product Engine

This block computes the dot product of two equal-length vectors of unsigned 8-bit elements without a full-width multiplier. Each operand element is cut into narrow bit slices. For every pairing of an operand-A slice with an operand-B slice, the engine forms a partial dot product over the whole vector. It weights that partial sum by a left shift equal to the combined bit position of the two slices, and folds it into a 64-bit running total.

A caller sets the vector length and a slice-width code for each operand, then pulses `start`. The caller streams element pairs on a valid/ready input, and the engine keeps them in a small local buffer. The engine then walks every slice pair internally. Operand-A slices form the outer loop, operand-B slices the inner loop, and the element index runs innermost. When all pairs are folded in, the engine raises `done` for one cycle. The 64-bit result and the number of busy cycles are valid at that point.

Narrow slices trade cycles for multiplier width. A 1-bit by 1-bit setting needs 64 passes over the vector through a 1x1 product. An 8-bit by 8-bit setting is the ordinary bit-parallel case and needs one pass.

Top module: `bsdot_engine`

## Requirements
- R1: A `start` pulse seen while idle captures `vec_len`, `cfg_a_lg` and `cfg_b_lg`. From the next cycle, `in_ready` is high and input is open.
- R2: After a start, exactly `vec_len` element pairs are taken, each on a cycle with `in_valid` and `in_ready` both high. Outside that window `in_ready` is low and `in_valid` has no effect on the result.
- R3: A width code c (0 to 3) selects a slice width w = 2^c, giving 8 >> c slices per element. Slice y of element e is (e >> (y*w)) & (2^w - 1).
- R4: For A-slice i and B-slice j, the partial dot product over all elements is shifted left by i*wA + j*wB and added to the total. The final result equals the sum of a[k]*b[k] for every pair of width codes.
- R5: Codes 3 and 3 give one slice per operand and one compute pass. The result is then the plain bit-parallel dot product.
- R6: An accepted start clears the 64-bit total, so `result` reads 0 on the following cycle and nothing from an earlier run carries over. The per-pass slice sum restarts at zero on every slice pair.
- R7: `done` is high for exactly one cycle, the cycle after the final accumulation. `result` and `busy_cycles` stay unchanged from then until the next accepted start.
- R8: A `start` pulse while busy (loading, computing or signalling done) is ignored. The running operation completes with its original length and widths.
- R9: The cycle counter is zero while idle and counts every load and compute cycle. With a gap-free input stream, `busy_cycles` at `done` equals len * (1 + nA*nB), where nA and nB are the slice counts.
- R10: Corner lengths work. A length of 1 and a length of 16 (the buffer depth) with all elements at 255 both give exact 64-bit results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (used only while idle) |
| vec_len | input | 5 | Number of element pairs, 1 to 16 |
| cfg_a_lg | input | 2 | Slice-width code for operand A (width 2^code) |
| cfg_b_lg | input | 2 | Slice-width code for operand B (width 2^code) |
| in_valid | input | 1 | Element pair present on in_a/in_b |
| in_ready | output | 1 | Engine accepts an element pair this cycle |
| in_a | input | 8 | Operand A element |
| in_b | input | 8 | Operand B element |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Dot-product result |
| busy_cycles | output | 32 | Load plus compute cycles of the last operation |

## Verification
The embedded assertions check these properties on every cycle:
- `in_ready` only opens after a start.
- `done` never lasts two cycles.
- The result holds while idle or done.
- A start while busy leaves the captured length alone.
- The load index stays below the length.
- The idle counter sits at zero.
- The total reads zero right after a clear.

Only the bench scenarios can show that the shifted slice sums rebuild the exact product for every width pairing and for the corner lengths. They also show the busy cycle count and that stray valid or start pulses leave the result untouched. A scoreboard compares each `done` against a plain multiply-accumulate model.

// File: rtl/bsdot_pkg.sv
// Shared types for the bit-sliced dot-product engine.
package bsdot_pkg;
    // Operation phases of the engine controller.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_COMP = 2'd2,
        ST_DONE = 2'd3
    } bsdot_state_e;
endpackage

// File: rtl/bsdot_vec_buf.sv
// Element-pair buffer: holds one vector of A and B elements, written once
// during loading and read by index during every slice pass.
// Assumes: the write index is below DEPTH; contents need no reset because
// every read location is written before it is read.
module bsdot_vec_buf #(
    parameter int DEPTH  = 16,
    parameter int ELEM_W = 8,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [ELEM_W-1:0] wa,
    input  logic [ELEM_W-1:0] wb,
    input  logic [IDX_W-1:0]  raddr,
    output logic [ELEM_W-1:0] ra,
    output logic [ELEM_W-1:0] rb
);
    logic [ELEM_W-1:0] mem_a [DEPTH];
    logic [ELEM_W-1:0] mem_b [DEPTH];

    // Store an accepted element pair.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_a[waddr] <= wa;
            mem_b[waddr] <= wb;
        end
    end

    // Asynchronous read of the element under process.
    assign ra = mem_a[raddr];
    assign rb = mem_b[raddr];
endmodule

// File: rtl/bsdot_slicer.sv
// Slice extractor: returns slice number idx of an element, with slice width
// 2^lg. Assumes idx is below ELEM_W >> lg so the bit position fits.
module bsdot_slicer #(
    parameter int ELEM_W = 8,
    parameter int SIDX_W = $clog2(ELEM_W),
    parameter int CODE_W = 2
) (
    input  logic [ELEM_W-1:0] elem,
    input  logic [SIDX_W-1:0] idx,
    input  logic [CODE_W-1:0] lg,
    output logic [ELEM_W-1:0] slice
);
    logic [SIDX_W-1:0] bit_pos;
    logic [ELEM_W:0]   span;
    logic [ELEM_W-1:0] mask;

    // Position, mask and extraction of the selected slice.
    always_comb begin
        bit_pos = SIDX_W'(idx << lg);
        span    = (ELEM_W+1)'(1) << (1 << lg);
        mask    = ELEM_W'(span - (ELEM_W+1)'(1));
        slice   = (elem >> bit_pos) & mask;
    end
endmodule

// File: rtl/bsdot_acc.sv
// Two-level accumulator: a slice sum gathers the products of one slice pair
// over the vector. On the last element it is shifted and folded into the
// wide total and restarts at zero.
// Assumes: clr and en are never high together.
module bsdot_acc #(
    parameter int PROD_W = 16,
    parameter int SACC_W = 21,
    parameter int ACC_W  = 64,
    parameter int SH_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              last,
    input  logic [PROD_W-1:0] prod,
    input  logic [SH_W-1:0]   shamt,
    output logic [ACC_W-1:0]  total
);
    logic [SACC_W-1:0] slice_q;
    logic [SACC_W-1:0] slice_nx;

    // Running slice sum including the current product.
    assign slice_nx = slice_q + SACC_W'(prod);

    // Slice-sum and total update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            slice_q <= '0;
            total   <= '0;
        end else if (en) begin
            if (last) begin
                slice_q <= '0;
                total   <= total + (ACC_W'(slice_nx) << shamt);
            end else begin
                slice_q <= slice_nx;
            end
        end
    end

    // R6: a clear leaves the total at zero.
    p_clear_total_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (total == '0));
endmodule

// File: rtl/bsdot_engine.sv
// Bit-sliced unsigned dot-product engine (top). It loads vec_len element
// pairs into a buffer and visits every slice pair (A outer, B inner,
// element innermost). Each shifted partial dot product goes into a 64-bit
// total. It signals done with the result and the busy cycle count.
// Assumes: 1 <= vec_len <= MAX_LEN; width codes select widths up to ELEM_W.
module bsdot_engine
    import bsdot_pkg::*;
#(
    parameter int ELEM_W = 8,
    parameter int MAX_LEN = 16,
    parameter int ACC_W  = 64,
    parameter int CYC_W  = 32,
    parameter int SH_W   = 8,
    parameter int CODE_W = 2,
    parameter int LEN_W  = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  vec_len,
    input  logic [CODE_W-1:0] cfg_a_lg,
    input  logic [CODE_W-1:0] cfg_b_lg,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ELEM_W-1:0] in_a,
    input  logic [ELEM_W-1:0] in_b,
    output logic              done,
    output logic [ACC_W-1:0]  result,
    output logic [CYC_W-1:0]  busy_cycles
);
    localparam int IDX_W  = $clog2(MAX_LEN);
    localparam int SIDX_W = $clog2(ELEM_W);
    localparam int PROD_W = 2 * ELEM_W;
    localparam int SACC_W = PROD_W + LEN_W;

    bsdot_state_e      state_q;
    logic [LEN_W-1:0]  len_q;
    logic [CODE_W-1:0] lga_q, lgb_q;
    logic [IDX_W-1:0]  idx_q;
    logic [SIDX_W-1:0] si_q, sj_q;
    logic [CYC_W-1:0]  cnt_q;
    logic [CYC_W-1:0]  cyc_out_q;

    logic              last_elem, last_si, last_sj, final_step;
    logic [ELEM_W-1:0] elem_a, elem_b, slc_a, slc_b;
    logic [PROD_W-1:0] prod;
    logic [SH_W-1:0]   shamt;
    logic              acc_clr, acc_en;

    // Loop-end conditions for element, B-slice and A-slice counters.
    always_comb begin
        last_elem  = (LEN_W'(idx_q) == (len_q - LEN_W'(1)));
        last_sj    = (sj_q == SIDX_W'((ELEM_W >> lgb_q) - 1));
        last_si    = (si_q == SIDX_W'((ELEM_W >> lga_q) - 1));
        final_step = (state_q == ST_COMP) && last_elem && last_sj && last_si;
    end

    // Controller: phase sequencing and the three nested loop counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            len_q   <= '0;
            lga_q   <= '0;
            lgb_q   <= '0;
            idx_q   <= '0;
            si_q    <= '0;
            sj_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        len_q   <= vec_len;
                        lga_q   <= cfg_a_lg;
                        lgb_q   <= cfg_b_lg;
                        idx_q   <= '0;
                        si_q    <= '0;
                        sj_q    <= '0;
                        state_q <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (in_valid) begin
                        if (last_elem) begin
                            idx_q   <= '0;
                            state_q <= ST_COMP;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                ST_COMP: begin
                    if (last_elem) begin
                        idx_q <= '0;
                        if (last_sj) begin
                            sj_q <= '0;
                            if (last_si) state_q <= ST_DONE;
                            else         si_q    <= si_q + SIDX_W'(1);
                        end else begin
                            sj_q <= sj_q + SIDX_W'(1);
                        end
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Busy-cycle counter and the copy reported with the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            cyc_out_q <= '0;
        end else begin
            if (state_q == ST_IDLE) cnt_q <= '0;
            else                    cnt_q <= cnt_q + CYC_W'(1);
            if (final_step) cyc_out_q <= cnt_q + CYC_W'(1);
        end
    end

    bsdot_vec_buf #(
        .DEPTH (MAX_LEN),
        .ELEM_W(ELEM_W),
        .IDX_W (IDX_W)
    ) i_buf (
        .clk  (clk),
        .we   (in_ready && in_valid),
        .waddr(idx_q),
        .wa   (in_a),
        .wb   (in_b),
        .raddr(idx_q),
        .ra   (elem_a),
        .rb   (elem_b)
    );

    bsdot_slicer #(.ELEM_W(ELEM_W), .SIDX_W(SIDX_W), .CODE_W(CODE_W)) i_slc_a (
        .elem(elem_a), .idx(si_q), .lg(lga_q), .slice(slc_a)
    );

    bsdot_slicer #(.ELEM_W(ELEM_W), .SIDX_W(SIDX_W), .CODE_W(CODE_W)) i_slc_b (
        .elem(elem_b), .idx(sj_q), .lg(lgb_q), .slice(slc_b)
    );

    // Slice product and combined slice weight for the current pass.
    always_comb begin
        prod    = PROD_W'(slc_a) * PROD_W'(slc_b);
        shamt   = SH_W'(si_q << lga_q) + SH_W'(sj_q << lgb_q);
        acc_clr = (state_q == ST_IDLE) && start;
        acc_en  = (state_q == ST_COMP);
    end

    bsdot_acc #(
        .PROD_W(PROD_W),
        .SACC_W(SACC_W),
        .ACC_W (ACC_W),
        .SH_W  (SH_W)
    ) i_acc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (acc_clr),
        .en   (acc_en),
        .last (last_elem),
        .prod (prod),
        .shamt(shamt),
        .total(result)
    );

    assign in_ready    = (state_q == ST_LOAD);
    assign done        = (state_q == ST_DONE);
    assign busy_cycles = cyc_out_q;

    // R1: input only opens in response to a start.
    p_ready_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> $past(start));

    // R2: the load index stays below the captured length.
    p_load_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |-> (LEN_W'(idx_q) < len_q));

    // R7: done lasts a single cycle.
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: result holds once computed until an accepted start.
    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DONE || state_q == ST_IDLE) && !start) |=> $stable(result));

    // R8: a start while busy leaves the captured length alone.
    p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start) |=> $stable(len_q));

    // R9: the busy counter sits at zero while idle.
    p_cnt_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q == ST_IDLE)) |-> (cnt_q == '0));
endmodule

// File: tb/test_bsdot_engine.sv
// Scoreboard bench: run_op pushes the reference result and cycle count,
// the monitor pops and compares them on every done pulse.
module test_bsdot_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  vec_len = '0;
    logic [1:0]  cfg_a_lg = '0;
    logic [1:0]  cfg_b_lg = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_a = '0;
    logic [7:0]  in_b = '0;
    logic        done;
    logic [63:0] result;
    logic [31:0] busy_cycles;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    logic [7:0]  va [16];
    logic [7:0]  vb [16];
    logic [63:0] q_res [$];
    logic [31:0] q_cyc [$];
    string       q_tag [$];

    always #5 clk = ~clk;

    bsdot_engine i_bsdot_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .vec_len(vec_len),
        .cfg_a_lg(cfg_a_lg), .cfg_b_lg(cfg_b_lg), .in_valid(in_valid),
        .in_ready(in_ready), .in_a(in_a), .in_b(in_b), .done(done),
        .result(result), .busy_cycles(busy_cycles)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: compare each completion against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && done === 1'b1) begin
            if (q_res.size() == 0) begin
                chk("R7 unexpected done", 64'd1, 64'd0);
            end else begin
                string t;
                logic [63:0] er;
                logic [31:0] ec;
                er = q_res.pop_front();
                ec = q_cyc.pop_front();
                t  = q_tag.pop_front();
                chk({t, " result"}, result, er);
                chk("R9 busy cycles", 64'(busy_cycles), 64'(ec));
            end
        end
    end

    // Driver: push the reference, start, stream gap-free, await done.
    task automatic run_op(input int len, input int la, input int lb,
                          input bit poke, input string tag);
        logic [63:0] exp_r = '0;
        int na, nb;
        for (int k = 0; k < len; k++) exp_r += 64'(va[k]) * 64'(vb[k]);
        na = 8 >> la;
        nb = 8 >> lb;
        q_res.push_back(exp_r);
        q_cyc.push_back(32'(len * (1 + na * nb)));
        q_tag.push_back(tag);
        @(negedge clk);
        start = 1'b1; vec_len = 5'(len); cfg_a_lg = 2'(la); cfg_b_lg = 2'(lb);
        @(negedge clk);
        start = 1'b0;
        chk("R6 total cleared after start", result, 64'd0);
        chk("R1 in_ready after start", 64'(in_ready), 64'd1);
        for (int k = 0; k < len; k++) begin
            in_valid = 1'b1; in_a = va[k]; in_b = vb[k];
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk("R2 in_ready closed after length", 64'(in_ready), 64'd0);
        if (poke) begin
            start = 1'b1; vec_len = 5'd1; cfg_a_lg = 2'd3; cfg_b_lg = 2'd3;
            @(negedge clk);
            start = 1'b0;
        end
        while (done !== 1'b1) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R7 result held after done", result, exp_r);
        chk("R7 done single cycle", 64'(done), 64'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired actual=%0d expected=done", cycles);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset in_ready", 64'(in_ready), 64'd0);
        chk("R7 reset done", 64'(done), 64'd0);
        chk("R6 reset result", result, 64'd0);
        chk("R9 reset busy_cycles", 64'(busy_cycles), 64'd0);

        // R2: in_valid while idle is not taken.
        in_valid = 1'b1; in_a = 8'hAA; in_b = 8'h55;
        repeat (3) begin
            @(negedge clk);
            chk("R2 idle in_ready low", 64'(in_ready), 64'd0);
        end
        in_valid = 1'b0;
        chk("R2 idle valid leaves result", result, 64'd0);

        // R3/R4: every width-code pairing, random lengths 1..8.
        for (int la = 0; la < 4; la++) begin
            for (int lb = 0; lb < 4; lb++) begin
                for (int k = 0; k < 16; k++) begin
                    va[k] = 8'($urandom_range(0, 255));
                    vb[k] = 8'($urandom_range(0, 255));
                end
                run_op(int'($urandom_range(1, 8)), la, lb, 1'b0, "R3 R4 width pairing");
            end
        end

        // R5: full-width slices give the parallel product.
        for (int k = 0; k < 16; k++) begin va[k] = 8'(k * 17 + 3); vb[k] = 8'(200 - k); end
        run_op(5, 3, 3, 1'b0, "R5 bit-parallel");

        // R10: maximum length, all ones, finest slices.
        for (int k = 0; k < 16; k++) begin va[k] = 8'hFF; vb[k] = 8'hFF; end
        run_op(16, 0, 0, 1'b0, "R10 max length");

        // R10: single element.
        va[0] = 8'd201; vb[0] = 8'd77;
        run_op(1, 1, 2, 1'b0, "R10 length one");

        // R8: start pulse in the middle of computing is ignored.
        for (int k = 0; k < 16; k++) begin va[k] = 8'(k + 100); vb[k] = 8'(3 * k + 1); end
        run_op(3, 0, 0, 1'b1, "R8 busy start");

        // R6: back-to-back run with fresh data carries nothing over.
        for (int k = 0; k < 16; k++) begin va[k] = 8'(k); vb[k] = 8'(k); end
        run_op(4, 2, 1, 1'b0, "R6 second run");

        repeat (4) @(negedge clk);
        chk("R7 no pending results", 64'(q_res.size()), 64'd0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule